// File: doc/BRIEF.md
# Bouncing Decimal Digit Counter

This block drives one seven-segment digit with a decimal value that climbs from 0 to 9 and then falls back to 0, over and over. It never shows an end digit twice in a row, so the display reads ...8-9-8... at the top and ...1-0-1... at the bottom. A free-running binary prescaler divides the system clock into a slow step tick. A one-bit direction register turns the count around at each end. A decoder turns the count into a segment pattern.

The decimal point changes level on every new digit, so it blinks at half the step rate. All pins are registered and active low. The segment bus is eight bits wide: bits 6..0 are the glyph segments g..a, and bit 7 is the decimal point. One digit-enable line, chosen by parameter, is held active. The others stay inactive.

Top module: `seg_bounce_top`

## Requirements
- R1: After a synchronous reset the count is 0, the direction is rising and the decimal point is off. While reset is held, `seg_n` is 8'hC0 (glyph 0 shown, decimal point dark).
- R2: While rising, each step tick raises the displayed value by exactly one. The value never leaves the range 0..9.
- R3: At the top end, the step after 9 shows 8. At the bottom end, the step after 0 shows 1. No end digit is displayed on two consecutive steps.
- R4: The decimal point, driven on `seg_n[7]` and active low (0 = lit), inverts on every step. It is lit after odd-numbered steps counted from reset.
- R5: Steps occur every 2^DIV_BITS clock cycles. Counting rising edges from the first edge with reset low, the first new digit appears on `seg_n` after edge 2^(DIV_BITS-1)+2. `seg_n` is stable between steps.
- R6: `seg_n[6:0]` carries the inverted active-high glyph with bit 0 = segment a and bit 6 = segment g. The glyph codes are 0:3F, 1:06, 2:5B, 3:4F, 4:66, 5:6D, 6:7D, 7:07, 8:7F, 9:6F, all in hexadecimal.
- R7: `dig_en_n` has exactly one bit low, namely bit DIGIT_SEL, at all times, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| seg_n | output | 8 | Bit 7 is the decimal point; bits 6..0 are segments g..a. All active low and registered |
| dig_en_n | output | NUM_DIGITS | Digit enables, active low and registered |

## Verification
A step tick is registered in the prescaler, the count updates one edge later, and the output register follows one edge after that. A digit change on `seg_n` is therefore due 2^(DIV_BITS-1)+2 edges after reset release, and then every 2^DIV_BITS edges. The bench counts edges from reset release and samples each expected digit on the falling edge just after the edge where it is due. It also samples one cycle before the first change, and mid-period, to confirm that nothing moves early or late. The reset check repeats this timing after a reset issued in the middle of a run.

// File: rtl/seg_bounce_pkg.sv
package seg_bounce_pkg;
  localparam int DIGIT_MAX = 9;
  localparam int CNT_W     = 4;

  typedef logic [CNT_W-1:0] digit_t;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;

  // active-high glyph, bit0 = segment a ... bit6 = segment g
  function automatic logic [6:0] glyph_of(digit_t v);
    logic [6:0] g;
    case (v)
      4'd0:    g = 7'h3F;
      4'd1:    g = 7'h06;
      4'd2:    g = 7'h5B;
      4'd3:    g = 7'h4F;
      4'd4:    g = 7'h66;
      4'd5:    g = 7'h6D;
      4'd6:    g = 7'h7D;
      4'd7:    g = 7'h07;
      4'd8:    g = 7'h7F;
      4'd9:    g = 7'h6F;
      default: g = 7'h00;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/sb_prescaler.sv
module sb_prescaler #(
  parameter int DIV_BITS = 25
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam logic [DIV_BITS-1:0] TICK_AT = {1'b0, {(DIV_BITS-1){1'b1}}};

  logic [DIV_BITS-1:0] div_q;

  // tick marks the rising edge of the divider's top bit
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else begin
      div_q <= div_q + 1'b1;
      tick  <= (div_q == TICK_AT);
    end
  end

  // R5: a tick lasts a single cycle
  a_r5_tick_single: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/sb_updown.sv
module sb_updown
  import seg_bounce_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   step,
  output digit_t count,
  output logic   dot_on
);
  localparam digit_t TOP = digit_t'(DIGIT_MAX);

  dir_e dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      dir_q  <= DIR_UP;
      dot_on <= 1'b0;
    end else if (step) begin
      dot_on <= ~dot_on;
      if (dir_q == DIR_UP) begin
        if (count >= TOP) begin
          count <= TOP - 1'b1;
          dir_q <= DIR_DOWN;
        end else begin
          count <= count + 1'b1;
        end
      end else begin
        if (count == '0) begin
          count <= digit_t'(1);
          dir_q <= DIR_UP;
        end else begin
          count <= count - 1'b1;
        end
      end
    end
  end

  // R2: the value stays within 0..9
  a_r2_range: assert property (@(posedge clk) disable iff (rst)
    count <= TOP);
  // R2/R3: successive values differ by exactly one
  a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
    step |=> (count == $past(count) + 4'd1) || (count == $past(count) - 4'd1));
  // R3: turnaround at the top end
  a_r3_top_turn: assert property (@(posedge clk) disable iff (rst)
    (step && count == TOP) |=> count == TOP - 4'd1);
  // R3: turnaround at the bottom end
  a_r3_bottom_turn: assert property (@(posedge clk) disable iff (rst)
    (step && count == 4'd0) |=> count == 4'd1);
  // R4: the dot inverts on every step
  a_r4_dot_toggle: assert property (@(posedge clk) disable iff (rst)
    step |=> dot_on != $past(dot_on));
  // R5: no change without a step
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(count) && $stable(dot_on));
endmodule

// File: rtl/sb_glyph.sv
module sb_glyph
  import seg_bounce_pkg::*;
(
  input  digit_t     value,
  output logic [6:0] glyph
);
  always_comb glyph = glyph_of(value);
endmodule

// File: rtl/seg_bounce_top.sv
module seg_bounce_top
  import seg_bounce_pkg::*;
#(
  parameter int DIV_BITS   = 25,
  parameter int NUM_DIGITS = 4,
  parameter int DIGIT_SEL  = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic [7:0]            seg_n,
  output logic [NUM_DIGITS-1:0] dig_en_n
);
  localparam logic [7:0] SEG_RST = {1'b1, ~glyph_of('0)};

  logic       tick;
  digit_t     count;
  logic       dot_on;
  logic [6:0] glyph;
  logic [NUM_DIGITS-1:0] en_pattern;

  sb_prescaler #(.DIV_BITS(DIV_BITS)) u_pre (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  sb_updown u_cnt (
    .clk   (clk),
    .rst   (rst),
    .step  (tick),
    .count (count),
    .dot_on(dot_on)
  );

  sb_glyph u_dec (
    .value(count),
    .glyph(glyph)
  );

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_en
    assign en_pattern[d] = (d != DIGIT_SEL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_n    <= SEG_RST;
      dig_en_n <= en_pattern;
    end else begin
      seg_n    <= {~dot_on, ~glyph};
      dig_en_n <= en_pattern;
    end
  end

  // R7: exactly one digit enabled once the output register is loaded
  a_r7_one_digit: assert property (@(posedge clk) disable iff (rst)
    $countones(~dig_en_n) == 1);
  // R6: the output follows the counter's dot a cycle later
  a_r6_dot_follow: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> seg_n[7] == !$past(dot_on));
endmodule

// File: tb/seg_bounce_top_tb_top.sv
module seg_bounce_top_tb_top;
  localparam int DIV_BITS = 4;
  localparam int NDIG     = 4;
  localparam int SEL      = 2;
  localparam int PERIOD   = 1 << DIV_BITS;
  localparam int FIRST    = (1 << (DIV_BITS - 1)) + 2;
  localparam int NSTEP    = 20;

  // expected digit after step i (i = 1..NSTEP)
  localparam int EXP_DIG [NSTEP] = '{1,2,3,4,5,6,7,8,9,8,7,6,5,4,3,2,1,0,1,2};
  localparam logic [6:0] GL [10] = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,
                                     7'h6D,7'h7D,7'h07,7'h7F,7'h6F};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] seg_n;
  logic [NDIG-1:0] dig_en_n;
  int tests = 0;
  int fails = 0;
  int now_e = 0;
  bit done = 0;

  always #5 clk = ~clk;

  seg_bounce_top #(.DIV_BITS(DIV_BITS), .NUM_DIGITS(NDIG), .DIGIT_SEL(SEL)) dut_i (
    .clk(clk), .rst(rst), .seg_n(seg_n), .dig_en_n(dig_en_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at edge %0d: actual %h expected %h", req, now_e, act, exp);
    end
  endtask

  task automatic adv_to(input int e);
    while (now_e < e) begin
      @(posedge clk);
      now_e++;
    end
    @(negedge clk);
  endtask

  function automatic logic [7:0] seg_exp(input int dig, input bit dot);
    return {~dot, ~GL[dig]};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset", seg_n, 8'hC0);
    chk("R7 reset", {4'h0, dig_en_n}, 8'h0B);
    rst = 1'b0;
    now_e = 0;
  endtask

  initial begin
    do_reset();
    adv_to(FIRST - 1);
    chk("R5 early", seg_n, 8'hC0);
    for (int i = 1; i <= NSTEP; i++) begin
      adv_to(FIRST + PERIOD * (i - 1));
      chk($sformatf("R2/R3/R4/R6 step%0d", i), seg_n, seg_exp(EXP_DIG[i-1], (i % 2) == 1));
      if (i == 9 || i == 18) begin
        adv_to(FIRST + PERIOD * (i - 1) + PERIOD / 2);
        chk("R5 hold", seg_n, seg_exp(EXP_DIG[i-1], (i % 2) == 1));
      end
    end
    chk("R7 run", {4'h0, dig_en_n}, 8'h0B);
    // reset in mid-run restarts count, dot and prescaler
    do_reset();
    adv_to(FIRST - 1);
    chk("R1 restart", seg_n, 8'hC0);
    adv_to(FIRST);
    chk("R1 first", seg_n, seg_exp(1, 1'b1));
    adv_to(FIRST + PERIOD - 1);
    chk("R5 period", seg_n, seg_exp(1, 1'b1));
    adv_to(FIRST + PERIOD);
    chk("R4 dot off", seg_n, seg_exp(2, 1'b0));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule